// File: doc/BRIEF.md
# Dual-Slope PWM Timer

The block is a 16-bit up/down counter that produces phase-correct (center-aligned) pulse-width modulation on two compare channels. The counter climbs from zero to a ceiling value, reverses, and descends back to zero. Because it counts in both directions, each output pulse is centred on the bottom of the count. The ceiling comes from one of five sources, picked by a 4-bit mode input: three fixed ceilings, a programmable period register, or the active value of compare channel 0.

Software writes the compare values into staging registers. The counter uses them only after the next ceiling event. This lets the duty cycle change in the middle of a period without producing a broken pulse. The counter moves only on clock cycles where the tick input is high, so an external prescaler sets its rate.

The block has sticky event flags, cleared by write-one-to-clear: a bottom (overflow) flag, a ceiling flag, and one match flag per channel. Each channel drives a registered waveform output. The output can be non-inverted, inverted, or held low.

Top module: `pcpwm_timer`

## Requirements
- R1: On each tick the counter moves one step: upward from 0 to the ceiling, then downward back to 0. The ceiling value and the zero value are each held for exactly one tick, so one period is 2·ceiling ticks. Cycles without a tick leave the counter unchanged.
- R2: The mode input selects the ceiling. Code 1 gives 0x00FF, code 2 gives 0x01FF, code 3 gives 0x03FF, code 10 uses the period register (address 2), and code 11 uses the active compare value of channel 0. Every other code freezes the counter.
- R3: Flag bit 0 (overflow) is set by the tick on which the counter leaves 0 while counting down.
- R4: The tick on which the counter leaves the ceiling while counting up is the ceiling event. At that event each channel copies its staging register (channel 0 at address 0, channel 1 at address 1) into its active compare value; before it, the old value stays in force. At the same event, flag bit 1 is set in mode 10 and flag bit 2 is set in mode 11.
- R5: Flag bit 2+i is set by any tick on which the counter equals channel i's active compare value.
- R6: In modes 1, 2 and 3, a write to a staging register keeps only the low 8, 9 or 10 bits of the data and clears the rest.
- R7: Output mode 2 is non-inverted. A match clears the output while counting up and sets it while counting down. A match at 0 counts as upward, and a match at the ceiling counts as downward. The output is therefore high for 2·C ticks of every period: always low for C = 0 and always high for C equal to the ceiling.
- R8: Output mode 3 gives the complement waveform, which is high for 2·(ceiling − C) ticks of every period.
- R9: A channel whose active compare value is above the ceiling never matches, never raises its flag, and keeps a constant output.
- R10: A write to address 3 clears every flag whose data bit is 1 and leaves the other flags unchanged. A flag set in the same cycle wins over the clear.
- R11: After reset the counter is 0 and counting up, the staging and active compare values are 0, all flags are clear, and the outputs are low.
- R12: Outputs are registered and change only on tick cycles. Output modes 0 and 1 drive the output low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| tick | input | 1 | Count enable from the prescaler |
| mode | input | 4 | Ceiling source and run select |
| out_mode | input | 2·N_CH | Two bits per channel: 2 non-inverted, 3 inverted, otherwise low |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | ADDR_W | Write address: channels 0..N_CH-1, then period, then flag clear |
| wr_data | input | CNT_W | Write data |
| cnt | output | CNT_W | Current counter value |
| flags | output | N_CH+2 | Sticky flags: bit 0 overflow, bit 1 ceiling, bit 2+i channel match |
| pwm | output | N_CH | Waveform outputs, one bit per channel |

## Verification
The counter is checked against a triangle computed arithmetically, tick by tick, with two different ceilings: the 8-bit fixed ceiling and a small period-register ceiling. Tick gaps are inserted to show that the count and the outputs stay put between ticks.

Duty cycle is measured by counting high samples over a whole period, for four kinds of compare value: a middle value in each polarity, zero, and exactly the ceiling. These separate the direction rule at the two ends from the general case. A compare value above the ceiling shows that a channel can be shut off.

A staging write whose value lies ahead of the counter on the up-slope, but which only becomes due on the down-slope, separates double buffering from an immediate update. The same write carries high bits that only the fixed-ceiling mask removes. Ceiling-from-compare mode is checked by the period it produces and by its flag timing.

// File: rtl/pcpwm_pkg.sv
package pcpwm_pkg;

  // ceiling source codes carried on the mode input
  localparam logic [3:0] MODE_FIX8   = 4'd1;
  localparam logic [3:0] MODE_FIX9   = 4'd2;
  localparam logic [3:0] MODE_FIX10  = 4'd3;
  localparam logic [3:0] MODE_PERIOD = 4'd10;
  localparam logic [3:0] MODE_CMP0   = 4'd11;

  typedef enum logic [1:0] {
    OUT_LOW0   = 2'd0,
    OUT_LOW1   = 2'd1,
    OUT_NONINV = 2'd2,
    OUT_INV    = 2'd3
  } out_mode_e;

  // flag vector layout
  localparam int FLG_OVF  = 0;
  localparam int FLG_CEIL = 1;
  localparam int FLG_CMP0 = 2;

endpackage

// File: rtl/pcpwm_ceiling_sel.sv
module pcpwm_ceiling_sel
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic [3:0]       mode,
  input  logic [CNT_W-1:0] period,
  input  logic [CNT_W-1:0] cmp0_act,
  output logic [CNT_W-1:0] ceiling,
  output logic             run,
  output logic             fixed
);

  localparam logic [CNT_W-1:0] CEIL8  = CNT_W'(255);
  localparam logic [CNT_W-1:0] CEIL9  = CNT_W'(511);
  localparam logic [CNT_W-1:0] CEIL10 = CNT_W'(1023);

  always_comb begin
    ceiling = '0;
    run     = 1'b1;
    fixed   = 1'b0;
    case (mode)
      MODE_FIX8:   begin ceiling = CEIL8;  fixed = 1'b1; end
      MODE_FIX9:   begin ceiling = CEIL9;  fixed = 1'b1; end
      MODE_FIX10:  begin ceiling = CEIL10; fixed = 1'b1; end
      MODE_PERIOD: ceiling = period;
      MODE_CMP0:   ceiling = cmp0_act;
      default:     run = 1'b0;
    endcase
  end

endmodule

// File: rtl/pcpwm_dual_cnt.sv
module pcpwm_dual_cnt #(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             step,
  input  logic [CNT_W-1:0] ceiling,
  output logic [CNT_W-1:0] cnt,
  output logic             dir_up,
  output logic             at_ceil,
  output logic             at_bot
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             up_q, up_d;

  always_comb begin
    cnt_d   = cnt_q;
    up_d    = up_q;
    at_ceil = step && up_q && (cnt_q >= ceiling);
    at_bot  = step && !up_q && (cnt_q == '0);
    if (at_ceil) begin
      up_d  = 1'b0;
      cnt_d = (cnt_q == '0) ? cnt_q : cnt_q - CNT_W'(1);
    end else if (at_bot) begin
      up_d  = 1'b1;
      cnt_d = CNT_W'(1);
    end else if (step) begin
      cnt_d = up_q ? cnt_q + CNT_W'(1) : cnt_q - CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      up_q  <= 1'b1;
    end else if (step) begin
      cnt_q <= cnt_d;
      up_q  <= up_d;
    end
  end

  assign cnt    = cnt_q;
  assign dir_up = up_q;

endmodule

// File: rtl/pcpwm_chan.sv
module pcpwm_chan
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_ni,
  input  logic             wr,
  input  logic [CNT_W-1:0] wdata,
  input  logic [CNT_W-1:0] mask,
  input  logic             load,
  input  logic             step,
  input  logic [CNT_W-1:0] cnt,
  input  logic             dir_up,
  input  logic [CNT_W-1:0] ceiling,
  input  logic [1:0]       omode,
  output logic [CNT_W-1:0] stage,
  output logic [CNT_W-1:0] act,
  output logic             match,
  output logic             pwm
);

  logic [CNT_W-1:0] stage_q, act_q;
  logic             pwm_q, pwm_d;
  logic             low_side;

  assign match = step && (cnt == act_q);
  // the zero end counts as upward, the ceiling end as downward
  assign low_side = (cnt == '0) || (dir_up && (cnt != ceiling));

  always_comb begin
    pwm_d = pwm_q;
    case (out_mode_e'(omode))
      OUT_NONINV: if (match) pwm_d = !low_side;
      OUT_INV:    if (match) pwm_d = low_side;
      default:    pwm_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      stage_q <= '0;
    end else if (wr) begin
      stage_q <= wdata & mask;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      act_q <= '0;
    end else if (load) begin
      act_q <= stage_q;
    end
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      pwm_q <= 1'b0;
    end else if (step) begin
      pwm_q <= pwm_d;
    end
  end

  assign stage = stage_q;
  assign act   = act_q;
  assign pwm   = pwm_q;

endmodule

// File: rtl/pcpwm_timer.sv
module pcpwm_timer
  import pcpwm_pkg::*;
#(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2,
  localparam int ADDR_W = $clog2(N_CH + 2),
  localparam int FLG_W  = N_CH + 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                tick,
  input  logic [3:0]          mode,
  input  logic [2*N_CH-1:0]   out_mode,
  input  logic                wr_en,
  input  logic [ADDR_W-1:0]   wr_addr,
  input  logic [CNT_W-1:0]    wr_data,
  output logic [CNT_W-1:0]    cnt,
  output logic [FLG_W-1:0]    flags,
  output logic [N_CH-1:0]     pwm
);

  localparam logic [ADDR_W-1:0] ADDR_PERIOD = ADDR_W'(N_CH);
  localparam logic [ADDR_W-1:0] ADDR_FLAGS  = ADDR_W'(N_CH + 1);

  logic [1:0]                   rst_sync_q;
  logic                         rst_ni;
  logic [CNT_W-1:0]             period_q;
  logic [CNT_W-1:0]             ceiling, mask;
  logic                         run, fixed, step;
  logic                         dir_up, at_ceil, at_bot;
  logic [N_CH-1:0][CNT_W-1:0]   cmp_stage, cmp_act;
  logic [N_CH-1:0]              match;
  logic [FLG_W-1:0]             flags_q, flags_d, flag_set, flag_clr;

  // asynchronous assertion, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_sync_q <= 2'b00;
    end else begin
      rst_sync_q <= {rst_sync_q[0], 1'b1};
    end
  end
  assign rst_ni = rst_sync_q[1];

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      period_q <= '0;
    end else if (wr_en && (wr_addr == ADDR_PERIOD)) begin
      period_q <= wr_data;
    end
  end

  pcpwm_ceiling_sel #(.CNT_W(CNT_W)) u_ceil (
    .mode     (mode),
    .period   (period_q),
    .cmp0_act (cmp_act[0]),
    .ceiling  (ceiling),
    .run      (run),
    .fixed    (fixed)
  );

  assign step = tick && run;
  assign mask = fixed ? ceiling : '1;

  pcpwm_dual_cnt #(.CNT_W(CNT_W)) u_cnt (
    .clk     (clk),
    .rst_ni  (rst_ni),
    .step    (step),
    .ceiling (ceiling),
    .cnt     (cnt),
    .dir_up  (dir_up),
    .at_ceil (at_ceil),
    .at_bot  (at_bot)
  );

  for (genvar i = 0; i < N_CH; i++) begin : g_ch
    pcpwm_chan #(.CNT_W(CNT_W)) u_ch (
      .clk     (clk),
      .rst_ni  (rst_ni),
      .wr      (wr_en && (wr_addr == ADDR_W'(i))),
      .wdata   (wr_data),
      .mask    (mask),
      .load    (at_ceil),
      .step    (step),
      .cnt     (cnt),
      .dir_up  (dir_up),
      .ceiling (ceiling),
      .omode   (out_mode[2*i +: 2]),
      .stage   (cmp_stage[i]),
      .act     (cmp_act[i]),
      .match   (match[i]),
      .pwm     (pwm[i])
    );
  end

  always_comb begin
    flag_set           = '0;
    flag_set[FLG_OVF]  = at_bot;
    flag_set[FLG_CEIL] = at_ceil && (mode == MODE_PERIOD);
    flag_set[FLG_CMP0 +: N_CH] = match;
    flag_set[FLG_CMP0] = match[0] || (at_ceil && (mode == MODE_CMP0));
    flag_clr = (wr_en && (wr_addr == ADDR_FLAGS)) ? wr_data[FLG_W-1:0] : '0;
    flags_d  = (flags_q & ~flag_clr) | flag_set;
  end

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      flags_q <= '0;
    end else begin
      flags_q <= flags_d;
    end
  end

  assign flags = flags_q;

endmodule

// File: rtl/pcpwm_timer_chk.sv
module pcpwm_timer_chk #(
  parameter int CNT_W = 16,
  parameter int N_CH  = 2,
  localparam int ADDR_W = $clog2(N_CH + 2),
  localparam int FLG_W  = N_CH + 2
) (
  input logic                      clk,
  input logic                      rst_ni,
  input logic                      tick,
  input logic                      run,
  input logic [3:0]                mode,
  input logic                      wr_en,
  input logic [ADDR_W-1:0]         wr_addr,
  input logic [CNT_W-1:0]          cnt,
  input logic                      dir_up,
  input logic                      at_ceil,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_stage,
  input logic [N_CH-1:0][CNT_W-1:0] cmp_act,
  input logic [FLG_W-1:0]          flags,
  input logic [N_CH-1:0]           pwm
);

  // R1
  cnt_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> $stable(cnt));

  // R2
  stop_hold_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !run |=> $stable(cnt));

  // R3
  bottom_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && run && !dir_up && (cnt == '0)) |=> flags[0]);

  // R4
  act_load_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !at_ceil |=> $stable(cmp_act));

  // R5
  match_flag_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (tick && run && (cnt == cmp_act[0])) |=> flags[2]);

  // R6
  mask_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    (wr_en && (wr_addr == '0) && (mode == 4'd1)) |=> (cmp_stage[0][CNT_W-1:8] == '0));

  // R10
  flag_rise_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> ((flags & ~$past(flags)) == '0));

  // R12
  pwm_idle_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !tick |=> $stable(pwm));

endmodule

bind pcpwm_timer pcpwm_timer_chk #(.CNT_W(CNT_W), .N_CH(N_CH)) u_chk (
  .clk       (clk),
  .rst_ni    (rst_ni),
  .tick      (tick),
  .run       (run),
  .mode      (mode),
  .wr_en     (wr_en),
  .wr_addr   (wr_addr),
  .cnt       (cnt),
  .dir_up    (dir_up),
  .at_ceil   (at_ceil),
  .cmp_stage (cmp_stage),
  .cmp_act   (cmp_act),
  .flags     (flags),
  .pwm       (pwm)
);

// File: tb/pcpwm_timer_tb.sv
module pcpwm_timer_tb;

  logic        clk = 1'b0;
  logic        rst_n, tick, wr_en;
  logic [3:0]  mode, out_mode;
  logic [1:0]  wr_addr;
  logic [15:0] wr_data;
  logic [15:0] cnt;
  logic [3:0]  flags;
  logic [1:0]  pwm;

  int nchk = 0;
  int nerr = 0;
  int k = 0;

  always #4 clk = ~clk;

  pcpwm_timer u_dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .mode(mode), .out_mode(out_mode),
    .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .cnt(cnt), .flags(flags), .pwm(pwm)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    nchk++;
    if (act != exp) begin
      nerr++;
      $display("FAIL %s: got %0d expected %0d (tick %0d)", req, act, exp, k);
    end
  endtask

  function automatic int tri_val(input int kk, input int top);
    int p;
    p = kk % (2 * top);
    return (p <= top) ? p : 2 * top - p;
  endfunction

  task automatic do_reset();
    rst_n = 1'b0; tick = 1'b0; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    mode = 4'd0; out_mode = 4'd0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    k = 0;
  endtask

  task automatic step(input int n);
    for (int i = 0; i < n; i++) begin
      tick = 1'b1;
      @(negedge clk);
      tick = 1'b0;
      k++;
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [15:0] d);
    wr_en = 1'b1; wr_addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic window(input int n, output int ha, output int hb);
    ha = 0; hb = 0;
    for (int i = 0; i < n; i++) begin
      step(1);
      ha += pwm[0];
      hb += pwm[1];
    end
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", nchk, nerr);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nchk++; nerr++;
    $display("FAIL R1 watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int ha, hb, found, per;
    logic [15:0] c0;
    logic [1:0]  p0;

    // ---------------- reset state, fixed 8-bit ceiling ----------------
    do_reset();
    chk("R11 cnt after reset", cnt, 0);
    chk("R11 pwm after reset", pwm, 0);
    chk("R11 flags after reset", flags, 0);

    mode = 4'd1; out_mode = {2'd3, 2'd2};
    wr(2'd0, 16'd100);
    wr(2'd1, 16'd40);
    for (int i = 0; i < 1020; i++) begin
      step(1);
      chk("R1 triangle ceiling 255", cnt, tri_val(k, 255));
      if (k == 300) wr(2'd3, 16'hF);
      if (k == 410) chk("R5 ch0 flag before match", flags[2], 0);
      if (k == 411) chk("R5 ch0 flag after match", flags[2], 1);
      if (k == 470) chk("R5 ch1 flag before match", flags[3], 0);
      if (k == 471) chk("R5 ch1 flag after match", flags[3], 1);
      if (k == 510) chk("R3 overflow before bottom", flags[0], 0);
      if (k == 511) chk("R3 overflow after bottom", flags[0], 1);
    end
    window(510, ha, hb);
    chk("R7 non-inverted duty C=100", ha, 200);
    chk("R8 inverted duty C=40", hb, 430);

    // tick gaps
    for (int i = 0; i < 6; i++) begin
      step(37);
      c0 = cnt; p0 = pwm;
      @(negedge clk);
      chk("R1 count held without tick", cnt, c0);
      chk("R12 outputs held without tick", pwm, p0);
      chk("R1 triangle after gap", cnt, tri_val(k, 255));
    end

    // frozen mode code
    c0 = cnt;
    mode = 4'd5;
    step(7);
    k -= 7;
    chk("R2 unlisted mode freezes count", cnt, c0);
    mode = 4'd1;

    // selective clear
    chk("R10 flags before clear", flags & 4'b1101, 4'b1101);
    wr(2'd3, 16'h0001);
    chk("R10 only bit 0 cleared", flags & 4'b1101, 4'b1100);

    // ---------------- double buffering and write masking ----------------
    do_reset();
    mode = 4'd1; out_mode = 4'd0;
    step(100);
    wr(2'd3, 16'hF);
    wr(2'd0, 16'h12C8);   // keeps 0xC8 = 200
    wr(2'd1, 16'h0300);   // keeps 0
    while (k < 511) begin
      step(1);
      if (k == 300) chk("R4 staged value not yet in force", flags[2], 0);
      if (k == 310) chk("R6 masked value before match", flags[2], 0);
      if (k == 311) chk("R6 masked value matches at 200", flags[2], 1);
      if (k == 510) chk("R6 masked zero before bottom", flags[3], 0);
      if (k == 511) chk("R6 masked zero matches at bottom", flags[3], 1);
      if (pwm != 2'b00) chk("R12 output mode 0 drives low", pwm, 0);
    end
    chk("R12 output mode 0 low at end", pwm, 0);

    // ---------------- period register ceiling ----------------
    do_reset();
    mode = 4'd10; out_mode = {2'd2, 2'd2};
    wr(2'd2, 16'd9);
    wr(2'd0, 16'd4);
    wr(2'd1, 16'd12);
    for (int i = 0; i < 36; i++) begin
      step(1);
      chk("R2 triangle ceiling from period", cnt, tri_val(k, 9));
      if (k == 9)  chk("R4 ceiling flag before event", flags[1], 0);
      if (k == 10) chk("R4 ceiling flag at event", flags[1], 1);
    end
    wr(2'd3, 16'hF);
    window(18, ha, hb);
    chk("R7 non-inverted duty C=4", ha, 8);
    chk("R9 compare above ceiling keeps output", hb, 0);
    chk("R9 compare above ceiling raises no flag", flags[3], 0);
    for (int i = 0; i < 18; i++) begin
      step(1);
      @(negedge clk);
      chk("R1 gapped triangle", cnt, tri_val(k, 9));
    end

    do_reset();
    mode = 4'd10; out_mode = {2'd2, 2'd2};
    wr(2'd2, 16'd9);
    wr(2'd0, 16'd0);
    wr(2'd1, 16'd9);
    step(36);
    window(18, ha, hb);
    chk("R7 compare zero stays low", ha, 0);
    chk("R7 compare at ceiling stays high", hb, 18);

    // ---------------- channel 0 as ceiling ----------------
    do_reset();
    mode = 4'd11; out_mode = 4'd0;
    wr(2'd0, 16'd7);
    step(20);
    wr(2'd3, 16'hF);
    found = 0;
    for (int i = 0; i < 20 && found == 0; i++) begin
      step(1);
      if (cnt == 16'd7) found = 1;
    end
    chk("R2 compare-0 ceiling reached", found, 1);
    chk("R4 compare-0 flag before event", flags[2], 0);
    step(1);
    chk("R4 compare-0 flag at event", flags[2], 1);
    chk("R4 no period flag in mode 11", flags[1], 0);
    chk("R1 reverses after ceiling", cnt, 6);
    per = 1;
    for (int i = 0; i < 40 && cnt != 16'd7; i++) begin
      step(1);
      per++;
    end
    chk("R2 compare-0 ceiling period", per, 14);

    finish_run();
  end

endmodule